// File: doc/BRIEF.md
# Single-Step Nonrestoring Divider

This block performs binary division one quotient bit at a time using the nonrestoring method. It holds three status bits: Q, M and T. Two setup commands prepare them. The unsigned setup clears all three. The signed setup takes the sign bits of the dividend-side and divisor-side operands. A step command then shifts the partial remainder left by one, shifting in T. It adds or subtracts the divisor, and the choice comes from comparing the previous Q with M. Software that wants a full quotient issues one step per quotient bit and gathers T after each step.

The block keeps the latest partial remainder in a register that drives `rem_out`. It also has an optional sequencer, enabled by `HAS_SEQ`. The sequencer loads a remainder and a divisor, then applies a programmed number of steps back to back, one per clock cycle. It ignores commands until the run has finished. It then raises `done` and holds its results until the next accepted command.

Top module: `divstep_unit`

## Requirements
- R1: After reset, `rem_out` is 0, the flags `q_out`, `m_out` and `t_out` are 0, and `busy` and `done` are 0.
- R2: An accepted command with `cmd_op` = 2'b00 (unsigned setup) clears Q, M and T, and loads `rem_out` with `rn_in`. Outputs are visible one cycle after the accepting edge.
- R3: An accepted command with `cmd_op` = 2'b01 (signed setup) sets Q to `rn_in[W-1]`, M to `rm_in[W-1]` and T to Q XOR M, and loads `rem_out` with `rn_in`.
- R4: An accepted command with `cmd_op` = 2'b10 (step) works as follows:
  - It forms {`rn_in[W-2:0]`, T}.
  - If the previous Q equals M, it subtracts `rm_in` from that value as a W+1-bit unsigned operation. Otherwise it adds `rm_in`.
- R5: After a step:
  - Q becomes `rn_in[W-1]` XOR M XOR bit W of the W+1-bit result.
  - T becomes NOT(Q XOR M).
  - M is unchanged.
- R6: Only the low W bits of the step result are written to `rem_out`, so a carry or borrow beyond bit W-1 wraps.
- R7: While `cmd_valid` is low and no run is in progress, `rem_out` and all flags hold their values.
- R8: An accepted command with `cmd_op` = 2'b11 (run) behaves as follows:
  - It loads the remainder from `rn_in` and the divisor from `rm_in`, with a nonzero `run_count` = N.
  - It keeps `busy` high for N cycles and applies one step per cycle, using the stored divisor and the current flags.
  - It then drops `busy` and raises `done` N cycles after the accepting edge. The result equals that of N single steps.
- R9: `done` and all results hold until the next accepted command, and any accepted command clears `done`.
- R10: Commands presented while `busy` is high are ignored.
- R11: A run with `run_count` = 0 raises `done` in the next cycle. It loads `rem_out` with `rn_in` and applies no step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 00 unsigned setup, 01 signed setup, 10 step, 11 run |
| rn_in | input | W | Partial remainder or dividend-side operand |
| rm_in | input | W | Divisor |
| run_count | input | CW | Number of steps for a run |
| rem_out | output | W | Current partial remainder |
| q_out | output | 1 | Q status bit |
| m_out | output | 1 | M status bit (divisor sign) |
| t_out | output | 1 | T status bit (quotient bit) |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished; results held |

## Verification
A wrong Q or M does not show at once. It shows on the next step, because that step then adds instead of subtracting: `rem_out` is off by twice the divisor and T flips. The bench therefore chains many steps against a flag model and compares every output after each command. In a run, one missing or extra cycle gives a wrong remainder. The same fault also makes `done` appear a cycle early or late, and the bench checks `done` at the exact cycle.

// File: rtl/divstep_pkg.sv
package divstep_pkg;
   typedef enum logic [1:0] {
      OP_USETUP = 2'b00,
      OP_SSETUP = 2'b01,
      OP_STEP   = 2'b10,
      OP_RUN    = 2'b11
   } divop_e;
endpackage

// File: rtl/divstep_alu.sv
module divstep_alu #(
   parameter int W         = 32,
   parameter bit ONE_ADDER = 1'b1
) (
   input  logic [W-1:0] rem_i,
   input  logic [W-1:0] dvsr_i,
   input  logic         q_i,
   input  logic         m_i,
   input  logic         t_i,
   output logic [W-1:0] rem_o,
   output logic         q_o,
   output logic         t_o
);
   localparam int XW = W + 1;

   logic [XW-1:0] shifted;
   logic [XW-1:0] result;
   logic          do_sub;

   assign shifted = {1'b0, rem_i[W-2:0], t_i};
   assign do_sub  = (q_i == m_i);

   generate
      if (ONE_ADDER) begin : g_shared
         logic [XW-1:0] addend;
         assign addend = do_sub ? ~{1'b0, dvsr_i} : {1'b0, dvsr_i};
         assign result = shifted + addend + {{(XW-1){1'b0}}, do_sub};
      end else begin : g_dual
         logic [XW-1:0] diff;
         logic [XW-1:0] sum;
         assign diff   = shifted - {1'b0, dvsr_i};
         assign sum    = shifted + {1'b0, dvsr_i};
         assign result = do_sub ? diff : sum;
      end
   endgenerate

   assign rem_o = result[W-1:0];
   assign q_o   = rem_i[W-1] ^ m_i ^ result[W];
   assign t_o   = ~(q_o ^ m_i);
endmodule

// File: rtl/divstep_seq.sv
module divstep_seq #(
   parameter int CW      = 6,
   parameter bit HAS_SEQ = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          clear,
   input  logic [CW-1:0] count_in,
   output logic          busy,
   output logic          done
);
   generate
      if (HAS_SEQ) begin : g_seq
         logic [CW-1:0] left;
         logic          busy_q;
         logic          done_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               left   <= '0;
               busy_q <= 1'b0;
               done_q <= 1'b0;
            end else if (start) begin
               left   <= count_in;
               busy_q <= (count_in != '0);
               done_q <= (count_in == '0);
            end else if (busy_q) begin
               left <= left - 1'b1;
               if (left == CW'(1)) begin
                  busy_q <= 1'b0;
                  done_q <= 1'b1;
               end
            end else if (clear) begin
               done_q <= 1'b0;
            end
         end

         assign busy = busy_q;
         assign done = done_q;

         AST_LEFT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
            busy_q |-> (left != '0)); // R8
         AST_RUN_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
            (busy_q && left == CW'(1)) |=> (done_q && !busy_q)); // R8
      end else begin : g_noseq
         assign busy = 1'b0;
         assign done = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/divstep_unit.sv
module divstep_unit
   import divstep_pkg::*;
#(
   parameter int W         = 32,
   parameter int CW        = 6,
   parameter bit HAS_SEQ   = 1'b1,
   parameter bit ONE_ADDER = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmd_valid,
   input  logic [1:0]    cmd_op,
   input  logic [W-1:0]  rn_in,
   input  logic [W-1:0]  rm_in,
   input  logic [CW-1:0] run_count,
   output logic [W-1:0]  rem_out,
   output logic          q_out,
   output logic          m_out,
   output logic          t_out,
   output logic          busy,
   output logic          done
);
   localparam int MSB = W - 1;

   generate
      if (W < 2) begin : g_bad_width
         $error("divstep_unit: W must be at least 2");
      end
      if (CW < 1) begin : g_bad_count
         $error("divstep_unit: CW must be at least 1");
      end
   endgenerate

   divop_e        op;
   logic          accept;
   logic          start_run;
   logic          clear_done;
   logic [W-1:0]  rem_q;
   logic [W-1:0]  dvsr_q;
   logic          q_q, m_q, t_q;
   logic [W-1:0]  src_rem, src_dvsr;
   logic [W-1:0]  alu_rem;
   logic          alu_q, alu_t;

   assign op         = divop_e'(cmd_op);
   assign accept     = cmd_valid && !busy;
   assign start_run  = accept && (op == OP_RUN) && HAS_SEQ;
   assign clear_done = accept && (op != OP_RUN);

   assign src_rem  = busy ? rem_q  : rn_in;
   assign src_dvsr = busy ? dvsr_q : rm_in;

   divstep_alu #(.W(W), .ONE_ADDER(ONE_ADDER)) u_alu (
      .rem_i (src_rem),
      .dvsr_i(src_dvsr),
      .q_i   (q_q),
      .m_i   (m_q),
      .t_i   (t_q),
      .rem_o (alu_rem),
      .q_o   (alu_q),
      .t_o   (alu_t)
   );

   divstep_seq #(.CW(CW), .HAS_SEQ(HAS_SEQ)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start_run),
      .clear   (clear_done),
      .count_in(run_count),
      .busy    (busy),
      .done    (done)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rem_q  <= '0;
         dvsr_q <= '0;
         q_q    <= 1'b0;
         m_q    <= 1'b0;
         t_q    <= 1'b0;
      end else if (busy) begin
         rem_q <= alu_rem;
         q_q   <= alu_q;
         t_q   <= alu_t;
      end else if (accept) begin
         unique case (op)
            OP_USETUP: begin
               rem_q <= rn_in;
               q_q   <= 1'b0;
               m_q   <= 1'b0;
               t_q   <= 1'b0;
            end
            OP_SSETUP: begin
               rem_q <= rn_in;
               q_q   <= rn_in[MSB];
               m_q   <= rm_in[MSB];
               t_q   <= rn_in[MSB] ^ rm_in[MSB];
            end
            OP_STEP: begin
               rem_q <= alu_rem;
               q_q   <= alu_q;
               t_q   <= alu_t;
            end
            OP_RUN: begin
               if (start_run) begin
                  rem_q  <= rn_in;
                  dvsr_q <= rm_in;
               end
            end
            default: ;
         endcase
      end
   end

   assign rem_out = rem_q;
   assign q_out   = q_q;
   assign m_out   = m_q;
   assign t_out   = t_q;

   AST_USETUP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && op == OP_USETUP) |=> (!q_out && !m_out && !t_out)); // R2
   AST_SSETUP_SIGNS: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && op == OP_SSETUP) |=> (q_out == $past(rn_in[MSB]) && m_out == $past(rm_in[MSB])
                                      && t_out == (q_out ^ m_out))); // R3
   AST_STEP_KEEPS_M: assert property (@(posedge clk) disable iff (!rst_n)
      (busy || (accept && op == OP_STEP)) |=> $stable(m_out)); // R5
   AST_STEP_T_REL: assert property (@(posedge clk) disable iff (!rst_n)
      (busy || (accept && op == OP_STEP)) |=> (t_out == !(q_out ^ m_out))); // R5
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !cmd_valid) |=> ($stable(rem_out) && $stable({q_out, m_out, t_out}))); // R7
   AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !cmd_valid) |=> (done && $stable(rem_out))); // R9
   AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cmd_valid) |=> $stable(m_out)); // R10
   AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R8
endmodule

// File: tb/sim_divstep_unit.sv
`timescale 1ns/1ps
module sim_divstep_unit;
   localparam int W  = 32;
   localparam int CW = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic [1:0]    cmd_op = 2'b00;
   logic [W-1:0]  rn_in = '0;
   logic [W-1:0]  rm_in = '0;
   logic [CW-1:0] run_count = '0;
   logic [W-1:0]  rem_out;
   logic          q_out, m_out, t_out, busy, done;

   int n_checks = 0;
   int n_fail   = 0;

   logic [W-1:0] mrem;
   logic         mq, mm, mt;

   always #4 clk = ~clk;

   divstep_unit #(.W(W), .CW(CW)) u0 (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .rn_in(rn_in), .rm_in(rm_in), .run_count(run_count),
      .rem_out(rem_out), .q_out(q_out), .m_out(m_out), .t_out(t_out),
      .busy(busy), .done(done)
   );

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic check_state(input string req);
      check(req, rem_out, mrem);
      check(req, {29'd0, q_out, m_out, t_out}, {29'd0, mq, mm, mt});
   endtask

   // one nonrestoring step per the requirements R4, R5, R6
   task automatic model_step(input logic [W-1:0] rn, input logic [W-1:0] rm);
      logic [W:0] sh, res;
      logic       nq;
      sh = {1'b0, rn[W-2:0], mt};
      if (mq == mm) res = sh - {1'b0, rm};
      else          res = sh + {1'b0, rm};
      nq   = rn[W-1] ^ mm ^ res[W];
      mq   = nq;
      mt   = ~(nq ^ mm);
      mrem = res[W-1:0];
   endtask

   task automatic issue(input logic [1:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic [CW-1:0] cnt);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; rn_in = a; rm_in = b; run_count = cnt;
      @(posedge clk); #1;
      cmd_valid = 1'b0;
   endtask

   task automatic do_cmd(input logic [1:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                         input string req);
      issue(op, a, b, '0);
      case (op)
         2'b00: begin mq = 0; mm = 0; mt = 0; mrem = a; end
         2'b01: begin mq = a[W-1]; mm = b[W-1]; mt = a[W-1] ^ b[W-1]; mrem = a; end
         default: model_step(a, b);
      endcase
      check_state(req);
   endtask

   task automatic do_run(input logic [W-1:0] a, input logic [W-1:0] b, input int n,
                         input bit noise);
      issue(2'b11, a, b, CW'(n));
      mrem = a;
      for (int i = 0; i < n; i++) model_step(mrem, b);
      if (n == 0) begin
         check("R11 done", {31'd0, done}, 32'd1);
         check_state("R11 no step");
         return;
      end
      check("R8 busy", {31'd0, busy}, 32'd1);
      check("R8 not done", {31'd0, done}, 32'd0);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (noise) begin
            cmd_valid = 1'b1; cmd_op = 2'(i % 4);
            rn_in = $urandom; rm_in = $urandom; run_count = CW'(3);
         end
         @(posedge clk); #1;
         cmd_valid = 1'b0;
         if (i < n - 1) check("R8 still busy", {31'd0, busy}, 32'd1);
      end
      check("R8 done", {31'd0, done}, 32'd1);
      check("R8 idle", {31'd0, busy}, 32'd0);
      check_state(noise ? "R10 ignored while busy" : "R8 run result");
   endtask

   initial begin
      #(8 * 150000);
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      mrem = '0; mq = 0; mm = 0; mt = 0;
      repeat (3) @(posedge clk);
      #1;
      // R1 reset values
      check_state("R1 reset");
      check("R1 busy/done", {30'd0, busy, done}, 32'd0);
      @(negedge clk); rst_n = 1'b1;

      // directed corners
      do_cmd(2'b01, 32'h8000_0000, 32'h0000_0001, "R3 signed setup");
      do_cmd(2'b01, 32'h1234_5678, 32'hF000_0000, "R3 signed setup mix");
      do_cmd(2'b00, 32'hDEAD_BEEF, 32'hFFFF_FFFF, "R2 unsigned setup");
      do_cmd(2'b10, 32'h0000_0001, 32'h0000_0005, "R4 subtract with borrow");
      do_cmd(2'b10, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R6 wrap");
      do_cmd(2'b01, 32'h7FFF_FFFF, 32'h8000_0000, "R3 setup for add");
      do_cmd(2'b10, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R5 add path and wrap R6");

      // R7 idle: inputs change without cmd_valid
      @(negedge clk); rn_in = 32'hAAAA_5555; rm_in = 32'h1; cmd_op = 2'b00;
      repeat (3) @(posedge clk);
      #1;
      check_state("R7 idle hold");

      // random mix of single commands
      for (int i = 0; i < 400; i++) begin
         int sel;
         sel = $urandom % 8;
         if (sel == 0)      do_cmd(2'b00, $urandom, $urandom, "R2 random");
         else if (sel == 1) do_cmd(2'b01, $urandom, $urandom, "R3 random");
         else               do_cmd(2'b10, $urandom, $urandom, "R4 R5 random step");
      end

      // sequencer runs
      do_cmd(2'b00, 32'd0, 32'd0, "R2 before run");
      do_run(32'd100, 32'd7, 32, 1'b0);
      repeat (3) @(posedge clk);
      #1;
      check("R9 done held", {31'd0, done}, 32'd1);
      check_state("R9 result held");
      do_cmd(2'b01, 32'h8765_4321, 32'h0000_0003, "R3 clears done");
      check("R9 done cleared", {31'd0, done}, 32'd0);
      do_run(32'hFFFF_FF00, 32'd3, 8, 1'b1);
      do_run(32'h1234_0000, 32'hABCD, 0, 1'b0);
      for (int i = 0; i < 20; i++)
         do_run($urandom, $urandom, 1 + ($urandom % 40), i[0]);

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule